// File: doc/BRIEF.md
# Incremental Converter Conversion Sequencer

This block produces every timing and control signal that one incremental delta-sigma conversion needs, starting from the fast reference clock of the chip. While idle it holds both the analog section and the digital filter powered down. A wake-up request starts a single conversion. The sequencer divides the reference clock by a power of two to obtain the sampling period. During a fixed number of modulator cycles it issues two non-overlapping integrator phases, a late copy of each phase, a comparator evaluate strobe and a chopper control line. It then powers the analog section down and keeps the filter clocked for a fixed number of decimation-only cycles. After that it powers itself down completely.

Within each sampling period the gap between the phases and the lag of the late copies are whole numbers of reference clocks. A start reset clears the integrators before the first phase. An end reset marks the close of the modulator run. A decimation strobe reaches the filter after every fixed group of sampling cycles. With the default parameters the reference clock is divided by 512, and the conversion lasts 120 modulator cycles plus 80 filter cycles. At a 16 MHz reference clock this gives a 31.25 kHz sampling rate, a 15.625 kHz chopper and a 6.4 ms conversion.

Below, P is the sampling period in reference clocks (2^SAMPLE_DIV_LOG2) and H = P/2. Position k is counted in reference clocks from the first clock after the wake-up request is accepted. Cycle n = k / P and slot s = k mod P. Outputs are registered, so position k appears at the ports one clock after the state it reflects.

Top module: `conv_sequencer`

## Requirements
- R1: While reset is low, and after it, until a wake-up is accepted: ana_pd_o and dig_pd_o are 1 and all other outputs are 0. A reset during a conversion returns the block to this state.
- R2: In modulator cycles (n < MOD_CYCLES), phi1_o is 1 exactly for slots GAP_CLKS..H-1 and phi2_o is 1 exactly for slots H+GAP_CLKS..P-1. Both are 0 in every other cycle and are never 1 together.
- R3: phi1_late_o and phi2_late_o repeat phi1_o and phi2_o LATE_CLKS reference clocks later. A late copy is never 1 together with the opposite undelayed phase.
- R4: dig_pd_o is 0 for exactly (MOD_CYCLES+DEC_CYCLES)*P consecutive clocks per conversion and then returns to 1.
- R5: ana_pd_o is 0 only during the first MOD_CYCLES*P positions of the conversion.
- R6: rst_begin_o is 1 in cycle 0 for slots 0..GAP_CLKS-1. rst_finish_o is 1 in cycle MOD_CYCLES, the first filter-only cycle, for slots 0..GAP_CLKS-1.
- R7: eval_o is 1 in modulator cycles for slots H..H+GAP_CLKS-1, the gap between the phases, and never together with phi1_o or phi2_o.
- R8: chop_o is 1 for all of each odd-numbered modulator cycle and 0 otherwise. It toggles once per sampling period and is high for half of the modulator cycles.
- R9: decim_stb_o is a one-clock pulse in slot P-1 of every cycle n with n mod DEC_EVERY = DEC_EVERY-1, counted over the whole conversion.
- R10: A wake-up request that arrives while a conversion runs has no effect. The running sequence is unchanged, and the block is idle after the first conversion ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| wake_i | input | 1 | Conversion request, sampled while idle |
| phi1_o | output | 1 | First integrator phase |
| phi2_o | output | 1 | Second integrator phase |
| phi1_late_o | output | 1 | First phase delayed by LATE_CLKS clocks |
| phi2_late_o | output | 1 | Second phase delayed by LATE_CLKS clocks |
| eval_o | output | 1 | Comparator evaluate strobe |
| chop_o | output | 1 | Chopper control |
| rst_begin_o | output | 1 | Integrator reset at conversion start |
| rst_finish_o | output | 1 | Reset at the end of the modulator run |
| decim_stb_o | output | 1 | Decimation strobe to the filter |
| ana_pd_o | output | 1 | Analog power-down, 1 = off |
| dig_pd_o | output | 1 | Digital power-down, 1 = off |

## Verification
The sequencer is driven with a single isolated request, and the full trace of every output is compared clock by clock against a model of the requirements. This separates errors in slot decoding from errors in cycle counting. A second conversion receives extra requests in both the modulator and the filter phases, which shows whether a busy request restarts or stretches the sequence. A reset in the middle of a conversion, followed by a fresh request, shows that no stale count survives into the next run.

// File: rtl/conv_seq_pkg.sv
// Shared types for the conversion sequencer.
package conv_seq_pkg;

    // Sequencer operating state.
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_MOD   = 2'd1,
        SEQ_DECIM = 2'd2
    } seq_state_e;

    // Decoded state flags handed from the controller to the output stage.
    typedef struct packed {
        logic busy;
        logic in_mod;
        logic in_dec;
        logic first_cyc;
        logic odd_cyc;
        logic dec_due;
    } seq_flags_t;

endpackage

// File: rtl/seq_timebase.sv
// Slot counter inside one sampling period.
// Assumes the period is a power of two, 2**PH_W reference clocks. The counter is
// held at zero while run_i is low, so every conversion starts at slot 0.
module seq_timebase #(
    parameter int PH_W = 9
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            run_i,
    output logic [PH_W-1:0] ph_o,
    output logic            ph_last_o
);
    logic [PH_W-1:0] ph_q;

    // Advance the slot while running; the natural wrap closes each period.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)    ph_q <= '0;
        else if (run_i) ph_q <= ph_q + PH_W'(1);
        else            ph_q <= '0;
    end

    assign ph_o      = ph_q;
    assign ph_last_o = &ph_q;
endmodule

// File: rtl/seq_ctrl.sv
// Conversion controller: idle -> modulator cycles -> filter-only cycles -> idle.
// Assumes MOD_CYCLES, DEC_CYCLES and DEC_EVERY are at least 1. Cycle counts
// advance on the last slot of each sampling period.
module seq_ctrl
    import conv_seq_pkg::*;
#(
    parameter int MOD_CYCLES = 120,
    parameter int DEC_CYCLES = 80,
    parameter int DEC_EVERY  = 40
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wake_i,
    input  logic       ph_last_i,
    output seq_flags_t flags_o
);
    localparam int CYC_MAX = (MOD_CYCLES > DEC_CYCLES) ? MOD_CYCLES : DEC_CYCLES;
    localparam int CYC_W   = $clog2(CYC_MAX + 1);
    localparam int DC_W    = $clog2(DEC_EVERY + 1);
    localparam logic [CYC_W-1:0] MOD_LAST = CYC_W'(MOD_CYCLES - 1);
    localparam logic [CYC_W-1:0] DEC_LAST = CYC_W'(DEC_CYCLES - 1);
    localparam logic [DC_W-1:0]  DC_LAST  = DC_W'(DEC_EVERY - 1);

    seq_state_e       state_q;
    logic [CYC_W-1:0] cyc_q;
    logic [DC_W-1:0]  dcnt_q;

    // State, per-phase cycle count and decimation group count.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= SEQ_IDLE;
            cyc_q   <= '0;
            dcnt_q  <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (wake_i) begin
                        state_q <= SEQ_MOD;
                        cyc_q   <= '0;
                        dcnt_q  <= '0;
                    end
                end
                SEQ_MOD: begin
                    if (ph_last_i) begin
                        dcnt_q <= (dcnt_q == DC_LAST) ? '0 : dcnt_q + DC_W'(1);
                        if (cyc_q == MOD_LAST) begin
                            state_q <= SEQ_DECIM;
                            cyc_q   <= '0;
                        end else begin
                            cyc_q <= cyc_q + CYC_W'(1);
                        end
                    end
                end
                SEQ_DECIM: begin
                    if (ph_last_i) begin
                        dcnt_q <= (dcnt_q == DC_LAST) ? '0 : dcnt_q + DC_W'(1);
                        if (cyc_q == DEC_LAST) begin
                            state_q <= SEQ_IDLE;
                            cyc_q   <= '0;
                        end else begin
                            cyc_q <= cyc_q + CYC_W'(1);
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Flag decode for the output stage.
    always_comb begin
        flags_o.busy      = (state_q != SEQ_IDLE);
        flags_o.in_mod    = (state_q == SEQ_MOD);
        flags_o.in_dec    = (state_q == SEQ_DECIM);
        flags_o.first_cyc = (cyc_q == '0);
        flags_o.odd_cyc   = cyc_q[0];
        flags_o.dec_due   = (dcnt_q == DC_LAST);
    end

    // A request during the filter phase must not disturb it.
    AST_BUSY_WAKE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == SEQ_DECIM && wake_i && !ph_last_i) |=> (state_q == SEQ_DECIM)); // R10
    // The modulator run always hands over to the filter, never straight to idle.
    AST_MOD_HANDS_OVER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == SEQ_MOD) |=> (state_q != SEQ_IDLE)); // R4
    // The modulator cycle count stays inside its run length.
    AST_MOD_CYC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == SEQ_MOD) |-> (cyc_q < CYC_W'(MOD_CYCLES))); // R5
endmodule

// File: rtl/seq_phase_gen.sv
// Registered output decode: phases, evaluate, chopper, resets, strobe, power-downs.
// Assumes 0 < GAP_CLKS < half period. Every output is registered, so nothing
// glitches toward the analog section.
module seq_phase_gen
    import conv_seq_pkg::*;
#(
    parameter int PH_W     = 9,
    parameter int GAP_CLKS = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  seq_flags_t      flags_i,
    input  logic [PH_W-1:0] ph_i,
    input  logic            ph_last_i,
    output logic            phi1_o,
    output logic            phi2_o,
    output logic            eval_o,
    output logic            chop_o,
    output logic            rst_begin_o,
    output logic            rst_finish_o,
    output logic            decim_stb_o,
    output logic            ana_pd_o,
    output logic            dig_pd_o
);
    localparam int              PERIOD   = 2 ** PH_W;
    localparam logic [PH_W-1:0] GAP_V    = PH_W'(GAP_CLKS);
    localparam logic [PH_W-1:0] HALF_V   = PH_W'(PERIOD / 2);
    localparam logic [PH_W-1:0] HALF_GAP = PH_W'(PERIOD / 2 + GAP_CLKS);

    logic in_gap_start;

    // Slot lies in the guard gap at the head of the period.
    assign in_gap_start = (ph_i < GAP_V);

    // Register every control line from the current slot and state.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            phi1_o       <= 1'b0;
            phi2_o       <= 1'b0;
            eval_o       <= 1'b0;
            chop_o       <= 1'b0;
            rst_begin_o  <= 1'b0;
            rst_finish_o <= 1'b0;
            decim_stb_o  <= 1'b0;
            ana_pd_o     <= 1'b1;
            dig_pd_o     <= 1'b1;
        end else begin
            phi1_o       <= flags_i.in_mod && !in_gap_start && (ph_i < HALF_V);
            phi2_o       <= flags_i.in_mod && (ph_i >= HALF_GAP);
            eval_o       <= flags_i.in_mod && (ph_i >= HALF_V) && (ph_i < HALF_GAP);
            chop_o       <= flags_i.in_mod && flags_i.odd_cyc;
            rst_begin_o  <= flags_i.in_mod && flags_i.first_cyc && in_gap_start;
            rst_finish_o <= flags_i.in_dec && flags_i.first_cyc && in_gap_start;
            decim_stb_o  <= flags_i.busy && flags_i.dec_due && ph_last_i;
            ana_pd_o     <= !flags_i.in_mod;
            dig_pd_o     <= !flags_i.busy;
        end
    end

    // The two integrator phases are never high together.
    AST_PHASE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(phi1_o && phi2_o)); // R2
    // The evaluate strobe sits in the gap, clear of both phases.
    AST_EVAL_IN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        eval_o |-> (!phi1_o && !phi2_o)); // R7
    // The start reset never coincides with an integrating phase.
    AST_RST_BEGIN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_begin_o |-> (!phi1_o && !phi2_o)); // R6
endmodule

// File: rtl/seq_late_line.sv
// Fixed delay of one control line by DEPTH reference clocks.
// Assumes DEPTH >= 1; the line is cleared by reset.
module seq_late_line #(
    parameter int DEPTH = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [DEPTH-1:0] sh_q;

    // Shift the input one stage per clock.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= DEPTH'({sh_q, d_i});
    end

    assign q_o = sh_q[DEPTH-1];
endmodule

// File: rtl/conv_sequencer.sv
// One-shot sequencer for an incremental converter.
// Assumes 1 <= LATE_CLKS <= GAP_CLKS < 2**(SAMPLE_DIV_LOG2-1), so a late copy
// ends before the opposite phase begins. A wake-up is honoured only while idle.
module conv_sequencer
    import conv_seq_pkg::*;
#(
    parameter int SAMPLE_DIV_LOG2 = 9,
    parameter int MOD_CYCLES      = 120,
    parameter int DEC_CYCLES      = 80,
    parameter int DEC_EVERY       = 40,
    parameter int GAP_CLKS        = 8,
    parameter int LATE_CLKS       = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wake_i,
    output logic phi1_o,
    output logic phi2_o,
    output logic phi1_late_o,
    output logic phi2_late_o,
    output logic eval_o,
    output logic chop_o,
    output logic rst_begin_o,
    output logic rst_finish_o,
    output logic decim_stb_o,
    output logic ana_pd_o,
    output logic dig_pd_o
);
    localparam int PH_W = SAMPLE_DIV_LOG2;

    seq_flags_t      flags;
    logic [PH_W-1:0] ph;
    logic            ph_last;
    logic [1:0]      phase_now;
    logic [1:0]      phase_late;

    seq_timebase #(.PH_W(PH_W)) u_timebase (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (flags.busy),
        .ph_o      (ph),
        .ph_last_o (ph_last)
    );

    seq_ctrl #(
        .MOD_CYCLES (MOD_CYCLES),
        .DEC_CYCLES (DEC_CYCLES),
        .DEC_EVERY  (DEC_EVERY)
    ) u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wake_i    (wake_i),
        .ph_last_i (ph_last),
        .flags_o   (flags)
    );

    seq_phase_gen #(
        .PH_W     (PH_W),
        .GAP_CLKS (GAP_CLKS)
    ) u_phase_gen (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .flags_i      (flags),
        .ph_i         (ph),
        .ph_last_i    (ph_last),
        .phi1_o       (phi1_o),
        .phi2_o       (phi2_o),
        .eval_o       (eval_o),
        .chop_o       (chop_o),
        .rst_begin_o  (rst_begin_o),
        .rst_finish_o (rst_finish_o),
        .decim_stb_o  (decim_stb_o),
        .ana_pd_o     (ana_pd_o),
        .dig_pd_o     (dig_pd_o)
    );

    assign phase_now = {phi2_o, phi1_o};

    // One delay line per integrator phase.
    for (genvar g = 0; g < 2; g++) begin : g_late
        seq_late_line #(.DEPTH(LATE_CLKS)) u_late (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .d_i    (phase_now[g]),
            .q_o    (phase_late[g])
        );
    end

    assign phi1_late_o = phase_late[0];
    assign phi2_late_o = phase_late[1];

    // A late phase never meets the opposite undelayed phase.
    AST_LATE_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(phi1_late_o && phi2_o) && !(phi2_late_o && phi1_o)); // R3
    // Integrator phases run only while the analog section is powered.
    AST_PHASES_NEED_POWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ana_pd_o |-> (!phi1_o && !phi2_o && !eval_o && !chop_o)); // R5
    // The analog section is never on while the digital section is off.
    AST_DIG_COVERS_ANA: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dig_pd_o |-> ana_pd_o); // R4
endmodule

// File: tb/test_conv_sequencer.sv
// Scoreboard bench: the driver queues the expected output trace and the
// monitor pops and compares one entry per clock.
module test_conv_sequencer;
    localparam int DIV   = 4;
    localparam int MODC  = 12;
    localparam int DECC  = 8;
    localparam int DEVRY = 4;
    localparam int GAP   = 2;
    localparam int LATE  = 1;
    localparam int P     = 2 ** DIV;
    localparam int H     = P / 2;
    localparam int N     = (MODC + DECC) * P;

    // Bit order: phi1 phi2 phi1_late phi2_late eval chop rst_begin rst_finish decim ana_pd dig_pd
    typedef logic [10:0] vec_t;
    localparam vec_t IDLE_VEC = 11'b000_0000_0011;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wake = 1'b0;
    logic phi1, phi2, phi1_late, phi2_late, eval_s, chop, rst_begin, rst_finish, decim, ana_pd, dig_pd;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    vec_t q[$];

    always #4 clk = ~clk;

    conv_sequencer #(
        .SAMPLE_DIV_LOG2 (DIV),
        .MOD_CYCLES      (MODC),
        .DEC_CYCLES      (DECC),
        .DEC_EVERY       (DEVRY),
        .GAP_CLKS        (GAP),
        .LATE_CLKS       (LATE)
    ) i_conv_sequencer (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .wake_i       (wake),
        .phi1_o       (phi1),
        .phi2_o       (phi2),
        .phi1_late_o  (phi1_late),
        .phi2_late_o  (phi2_late),
        .eval_o       (eval_s),
        .chop_o       (chop),
        .rst_begin_o  (rst_begin),
        .rst_finish_o (rst_finish),
        .decim_stb_o  (decim),
        .ana_pd_o     (ana_pd),
        .dig_pd_o     (dig_pd)
    );

    function automatic vec_t actual();
        return {phi1, phi2, phi1_late, phi2_late, eval_s, chop, rst_begin, rst_finish, decim, ana_pd, dig_pd};
    endfunction

    // Phase model: which = 1 for the first phase, 2 for the second.
    function automatic logic model_phase(int k, int which);
        int n, s;
        if (k < 0) return 1'b0;
        n = k / P;
        s = k % P;
        if (n >= MODC) return 1'b0;
        if (which == 1) return (s >= GAP) && (s < H);
        return (s >= H + GAP);
    endfunction

    function automatic vec_t expect_at(int k);
        int   n, s;
        logic md;
        vec_t v;
        n  = k / P;
        s  = k % P;
        md = (n < MODC);
        v[10] = model_phase(k, 1);
        v[9]  = model_phase(k, 2);
        v[8]  = model_phase(k - LATE, 1);
        v[7]  = model_phase(k - LATE, 2);
        v[6]  = md && (s >= H) && (s < H + GAP);
        v[5]  = md && (n % 2 == 1);
        v[4]  = (n == 0) && (s < GAP);
        v[3]  = (n == MODC) && (s < GAP);
        v[2]  = (n % DEVRY == DEVRY - 1) && (s == P - 1);
        v[1]  = !md;
        v[0]  = 1'b0;
        return v;
    endfunction

    function automatic string tag_of(int b);
        case (b)
            10, 9:   return "R2 phase";
            8, 7:    return "R3 late phase";
            6:       return "R7 eval";
            5:       return "R8 chop";
            4, 3:    return "R6 reset";
            2:       return "R9 decim strobe";
            1:       return "R5 analog pd";
            default: return "R4 digital pd";
        endcase
    endfunction

    task automatic check_bit(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: one expected vector per clock, sampled 2 ns after the edge.
    always @(posedge clk) begin
        vec_t e, a;
        #2;
        if (rst_n && !done) begin
            e = (q.size() > 0) ? q.pop_front() : IDLE_VEC;
            a = actual();
            for (int b = 0; b < 11; b++) check_bit(tag_of(b), a[b], e[b]);
        end
    end

    // Driver: raise wake for one clock and queue the full expected trace.
    task automatic launch();
        @(negedge clk);
        wake = 1'b1;
        q.push_back(IDLE_VEC);
        for (int k = 0; k < N; k++) q.push_back(expect_at(k));
        @(negedge clk);
        wake = 1'b0;
    endtask

    task automatic run_conv(bit poke);
        launch();
        for (int i = 0; i < N + 3; i++) begin
            @(negedge clk);
            wake = poke && (i == 3 * P || i == MODC * P + 5 || i == 5 * P + 1);
        end
        wake = 1'b0;
        check_bit("R4 trace consumed", q.size() == 0, 1'b1);
        if (poke) begin
            check_bit("R10 idle after busy wake (dig)", dig_pd, 1'b1);
            check_bit("R10 idle after busy wake (ana)", ana_pd, 1'b1);
        end
    endtask

    task automatic check_idle_r1();
        vec_t a;
        a = actual();
        for (int b = 0; b < 11; b++) check_bit("R1 reset state", a[b], IDLE_VEC[b]);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R4 actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_idle_r1();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_idle_r1();

        run_conv(1'b0);
        repeat (5) @(negedge clk);
        run_conv(1'b1);

        // Reset in the middle of a conversion, then a clean restart.
        launch();
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        q.delete();
        repeat (2) @(negedge clk);
        check_idle_r1();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_idle_r1();
        run_conv(1'b0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule